// File: doc/BRIEF.md
# Power Mode Sequencer with Inactivity and Device Idle Timers

This block steps an embedded system between a fast clock mode and a slow clock mode. While the system is busy, the block keeps it in the fast mode. A group of activity sources, each of which a mask bit can enable, resets an inactivity timer. If the timer counts down without any enabled activity, the block drops to the slow mode. The timer counts 512 Hz timebase ticks. A prescaler can turn those ticks into a coarse 16 Hz count, so a single 8-bit limit covers either a short range or a long range of timeouts. Any enabled activity in the slow mode brings the system back to the fast mode. Battery-low inputs can be set either to force the slow mode or to raise a one-cycle SMI request.

A bank of power-control pins starts from fixed reset levels. Each pin can then be given its own level for each mode, and the pins take on the new mode's levels when the mode changes. A separate device idle timer watches I/O strobes that fall inside one programmed address window. If that window sees no access for a programmed number of ticks, the timer drives a selected control pin high to switch the device off.

Top module: `pm_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 00 (fast mode), `clk_fast_o` is 1, `smi_req_o` is 0 and `pmc_o` equals the reset pattern (default 5'b01000, so only pin 3 is high). `mode_o` only ever takes the values 00 and 01, and `clk_fast_o` is 1 exactly when `mode_o` is 00.
- R2: With register 1 bit 0 cleared (fine range), and idle limit N (register 0) not zero, the mode becomes 01 on the edge that takes the N-th tick after the last enabled activity. Until that edge it stays 00.
- R3: With register 1 bit 0 set (coarse range), the drop to 01 happens on the N×PRESCALE-th tick after the last enabled activity (PRESCALE defaults to 32).
- R4: Enabled activity in the fast mode reloads both the idle timer and the prescaler, so the countdown starts over.
- R5: An activity source whose bit in the mask (register 4) is 0 neither reloads the timer nor wakes the block.
- R6: In mode 01, enabled activity returns the mode to 00 on the next clock edge and reloads the idle timer, unless a battery input is forcing the slow mode.
- R7: An idle limit of 0 disables the drop to the slow mode.
- R8: With register 1 bit 1 cleared, any high `batt_low_i` bit forces mode 01 from the next edge on and holds it there. Activity does not wake the block while that bit stays high.
- R9: With register 1 bit 1 set, a rising edge of any `batt_low_i` bit makes `smi_req_o` high for exactly one cycle, on the cycle after the edge is sampled. The mode does not change.
- R10: Register 2 holds the pin levels for mode 00 and register 3 holds them for mode 01. Writing these registers leaves `pmc_o` unchanged. `pmc_o` loads the levels of the new mode on the edge where the mode changes.
- R11: An I/O strobe whose address bits [ADDR_W-1:ADDR_W-8] equal register 5 loads the device timer from register 6. If register 6 ticks then pass with no access in that window, the pin chosen by register 1 bits [4:2] is driven high.
- R12: A strobe outside the window neither restarts the device timer nor clears the switched-off state. A strobe inside the window clears the switched-off state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| tick_i | input | 1 | One-cycle pulse at 512 Hz |
| act_src_i | input | NUM_ACT | Activity-detect pulses |
| io_stb_i | input | 1 | I/O access strobe |
| io_addr_i | input | ADDR_W | I/O access address |
| batt_low_i | input | NUM_BATT | Battery-low indications, active high |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_addr_i | input | 3 | Configuration register index |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| mode_o | output | 2 | Current mode code: 00 fast, 01 slow |
| clk_fast_o | output | 1 | High while the fast clock is selected |
| smi_req_o | output | 1 | One-cycle SMI request |
| pmc_o | output | NUM_PINS | Power-control pin levels |

## Verification
The bench sweeps the idle limit over 1 to 8 in the fine range and over 1 to 3 in the coarse range. In each case it checks that the mode is still fast one tick before the limit and slow exactly on the limit tick, which exposes off-by-one and prescaler-ratio errors. Activity is injected partway through a countdown, once from an enabled source and once from a masked source. Telling a reload apart from an ignored pulse shows whether the masking works. Both battery actions and the per-mode pin levels are exercised. The device window is probed with strobes inside and outside the address range, which separates a true restart from a stray one.

// File: rtl/pm_mode_pkg.sv
package pm_mode_pkg;

   typedef enum logic [1:0] {
      PM_FAST = 2'b00,
      PM_SLOW = 2'b01,
      PM_RSV2 = 2'b10,
      PM_RSV3 = 2'b11
   } pm_mode_e;

   localparam int PM_NUM_MODES = 4;

   localparam logic [2:0] CFG_IDLE_LIM  = 3'd0;
   localparam logic [2:0] CFG_CTRL      = 3'd1;
   localparam logic [2:0] CFG_LVL_FAST  = 3'd2;
   localparam logic [2:0] CFG_LVL_SLOW  = 3'd3;
   localparam logic [2:0] CFG_ACT_MASK  = 3'd4;
   localparam logic [2:0] CFG_DEV_BASE  = 3'd5;
   localparam logic [2:0] CFG_DEV_LIM   = 3'd6;

   localparam int CTRL_COARSE_BIT = 0;
   localparam int CTRL_BAT_SMI_BIT = 1;
   localparam int CTRL_DEV_SEL_LSB = 2;

endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
   parameter int PRESCALE = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clear_i,
   input  logic coarse_i,
   output logic tick_o
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   logic [PW-1:0] cnt_q;
   logic          coarse_tick;

   generate
      if (PRESCALE < 2) begin : g_bad
         $error("pm_tick_gen: PRESCALE must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign coarse_tick = tick_i && (cnt_q == LAST);
   assign tick_o      = coarse_i ? coarse_tick : tick_i;

endmodule

// File: rtl/pm_down_timer.sv
module pm_down_timer #(
   parameter int          W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         expire_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = dec_i && !load_i && (cnt_q == W'(1));

endmodule

// File: rtl/pm_pin_ctrl.sv
module pm_pin_ctrl
   import pm_mode_pkg::*;
#(
   parameter int                 NUM_PINS   = 5,
   parameter logic [NUM_PINS-1:0] RST_LEVELS = 5'b01000,
   parameter int                 SELW       = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  pm_mode_e                         mode_q_i,
   input  pm_mode_e                         mode_nxt_i,
   input  logic [PM_NUM_MODES*NUM_PINS-1:0] lvl_tab_i,
   input  logic                             dev_off_i,
   input  logic [SELW-1:0]                  dev_sel_i,
   output logic [NUM_PINS-1:0]              pin_q_o,
   output logic [NUM_PINS-1:0]              pins_o
);
   logic [NUM_PINS-1:0] pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= RST_LEVELS;
      end else if (mode_nxt_i != mode_q_i) begin
         pin_q <= lvl_tab_i[int'(mode_nxt_i)*NUM_PINS +: NUM_PINS];
      end
   end

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         assign pins_o[i] = pin_q[i] | (dev_off_i && (dev_sel_i == SELW'(i)));
      end
   endgenerate

   assign pin_q_o = pin_q;

endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
   import pm_mode_pkg::*;
#(
   parameter int                  NUM_ACT    = 4,
   parameter int                  NUM_BATT   = 2,
   parameter int                  NUM_PINS   = 5,
   parameter int                  ADDR_W     = 10,
   parameter int                  CFG_DW     = 8,
   parameter int                  PRESCALE   = 32,
   parameter logic [NUM_PINS-1:0] RST_LEVELS = 5'b01000,
   parameter logic [CFG_DW-1:0]   IDLE_RST   = 8'd16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic [NUM_ACT-1:0]  act_src_i,
   input  logic                io_stb_i,
   input  logic [ADDR_W-1:0]   io_addr_i,
   input  logic [NUM_BATT-1:0] batt_low_i,
   input  logic                cfg_we_i,
   input  logic [2:0]          cfg_addr_i,
   input  logic [CFG_DW-1:0]   cfg_wdata_i,
   output logic [1:0]          mode_o,
   output logic                clk_fast_o,
   output logic                smi_req_o,
   output logic [NUM_PINS-1:0] pmc_o
);
   localparam int SELW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   generate
      if (NUM_PINS > CFG_DW) begin : g_chk_pins
         $error("pm_mode_ctrl: NUM_PINS exceeds CFG_DW");
      end
      if (NUM_ACT > CFG_DW) begin : g_chk_act
         $error("pm_mode_ctrl: NUM_ACT exceeds CFG_DW");
      end
      if (ADDR_W < CFG_DW) begin : g_chk_addr
         $error("pm_mode_ctrl: ADDR_W must be at least CFG_DW");
      end
      if (CTRL_DEV_SEL_LSB + SELW > CFG_DW) begin : g_chk_sel
         $error("pm_mode_ctrl: device select field does not fit");
      end
   endgenerate

   // configuration registers
   logic [CFG_DW-1:0]   cfg_idle_lim;
   logic [CFG_DW-1:0]   cfg_ctrl;
   logic [NUM_PINS-1:0] cfg_lvl_fast;
   logic [NUM_PINS-1:0] cfg_lvl_slow;
   logic [NUM_ACT-1:0]  cfg_act_mask;
   logic [CFG_DW-1:0]   cfg_dev_base;
   logic [CFG_DW-1:0]   cfg_dev_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_idle_lim <= IDLE_RST;
         cfg_ctrl     <= '0;
         cfg_lvl_fast <= RST_LEVELS;
         cfg_lvl_slow <= RST_LEVELS;
         cfg_act_mask <= '1;
         cfg_dev_base <= '0;
         cfg_dev_lim  <= '0;
      end else if (cfg_we_i) begin
         case (cfg_addr_i)
            CFG_IDLE_LIM: cfg_idle_lim <= cfg_wdata_i;
            CFG_CTRL:     cfg_ctrl     <= cfg_wdata_i;
            CFG_LVL_FAST: cfg_lvl_fast <= cfg_wdata_i[NUM_PINS-1:0];
            CFG_LVL_SLOW: cfg_lvl_slow <= cfg_wdata_i[NUM_PINS-1:0];
            CFG_ACT_MASK: cfg_act_mask <= cfg_wdata_i[NUM_ACT-1:0];
            CFG_DEV_BASE: cfg_dev_base <= cfg_wdata_i;
            CFG_DEV_LIM:  cfg_dev_lim  <= cfg_wdata_i;
            default: ;
         endcase
      end
   end

   logic            coarse_sel;
   logic            bat_smi;
   logic [SELW-1:0] dev_sel;

   assign coarse_sel = cfg_ctrl[CTRL_COARSE_BIT];
   assign bat_smi    = cfg_ctrl[CTRL_BAT_SMI_BIT];
   assign dev_sel    = cfg_ctrl[CTRL_DEV_SEL_LSB +: SELW];

   // activity and battery qualification
   logic act_hit;
   logic batt_any;
   logic force_slow;
   logic batt_q;
   logic smi_q;

   assign act_hit    = |(act_src_i & cfg_act_mask);
   assign batt_any   = |batt_low_i;
   assign force_slow = batt_any && !bat_smi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         batt_q <= 1'b0;
         smi_q  <= 1'b0;
      end else begin
         batt_q <= batt_any;
         smi_q  <= batt_any && !batt_q && bat_smi;
      end
   end

   // inactivity timer
   pm_mode_e mode_q;
   pm_mode_e mode_nxt;
   logic     eff_tick;
   logic     idle_expire;

   pm_tick_gen #(
      .PRESCALE (PRESCALE)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .clear_i  (act_hit),
      .coarse_i (coarse_sel),
      .tick_o   (eff_tick)
   );

   pm_down_timer #(
      .W       (CFG_DW),
      .RST_VAL (IDLE_RST)
   ) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (act_hit),
      .load_val_i (cfg_idle_lim),
      .dec_i      (eff_tick && (mode_q == PM_FAST)),
      .expire_o   (idle_expire)
   );

   // mode state machine
   always_comb begin
      mode_nxt = mode_q;
      case (mode_q)
         PM_FAST: if (force_slow || idle_expire) mode_nxt = PM_SLOW;
         PM_SLOW: if (act_hit && !force_slow)    mode_nxt = PM_FAST;
         default: mode_nxt = PM_FAST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PM_FAST;
      else        mode_q <= mode_nxt;
   end

   // device idle timer on an I/O address window
   logic io_hit;
   logic dev_expire;
   logic dev_off_q;

   assign io_hit = io_stb_i && (io_addr_i[ADDR_W-1 -: CFG_DW] == cfg_dev_base);

   pm_down_timer #(
      .W       (CFG_DW),
      .RST_VAL ('0)
   ) u_dev (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (io_hit),
      .load_val_i (cfg_dev_lim),
      .dec_i      (tick_i),
      .expire_o   (dev_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dev_off_q <= 1'b0;
      else if (io_hit)     dev_off_q <= 1'b0;
      else if (dev_expire) dev_off_q <= 1'b1;
   end

   // control pins
   logic [PM_NUM_MODES*NUM_PINS-1:0] lvl_tab;
   logic [NUM_PINS-1:0]              pin_q;

   assign lvl_tab = {RST_LEVELS, RST_LEVELS, cfg_lvl_slow, cfg_lvl_fast};

   pm_pin_ctrl #(
      .NUM_PINS   (NUM_PINS),
      .RST_LEVELS (RST_LEVELS),
      .SELW       (SELW)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_q_i   (mode_q),
      .mode_nxt_i (mode_nxt),
      .lvl_tab_i  (lvl_tab),
      .dev_off_i  (dev_off_q),
      .dev_sel_i  (dev_sel),
      .pin_q_o    (pin_q),
      .pins_o     (pmc_o)
   );

   assign mode_o     = mode_q;
   assign clk_fast_o = (mode_q == PM_FAST);
   assign smi_req_o  = smi_q;

endmodule

module pm_mode_chk #(
   parameter int NUM_ACT  = 4,
   parameter int NUM_BATT = 2,
   parameter int NUM_PINS = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          mode_o,
   input logic                clk_fast_o,
   input logic                smi_o,
   input logic [NUM_ACT-1:0]  act_src,
   input logic [NUM_ACT-1:0]  act_mask,
   input logic [NUM_BATT-1:0] batt_low,
   input logic                bat_smi,
   input logic [NUM_PINS-1:0] pin_q
);
   p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o[1] == 1'b0) && (clk_fast_o == (mode_o == 2'b00)));

   p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01 && |(act_src & act_mask) && !(|batt_low && !bat_smi))
      |=> (mode_o == 2'b00));

   p_force_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|batt_low && !bat_smi) |=> (mode_o == 2'b01));

   p_smi_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      smi_o |=> !smi_o);

   p_smi_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      smi_o |-> ($past(|batt_low) && $past(bat_smi)));

   p_pins_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mode_o) |-> $stable(pin_q));
endmodule

bind pm_mode_ctrl pm_mode_chk #(
   .NUM_ACT  (NUM_ACT),
   .NUM_BATT (NUM_BATT),
   .NUM_PINS (NUM_PINS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_o     (mode_o),
   .clk_fast_o (clk_fast_o),
   .smi_o      (smi_req_o),
   .act_src    (act_src_i),
   .act_mask   (cfg_act_mask),
   .batt_low   (batt_low_i),
   .bat_smi    (bat_smi),
   .pin_q      (pin_q)
);

// File: tb/sim_pm_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pm_mode_ctrl;
   localparam int NUM_ACT = 4, NUM_BATT = 2, NUM_PINS = 5, ADDR_W = 10, PRESCALE = 32;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, io_stb = 1'b0, we = 1'b0;
   logic [NUM_ACT-1:0]  act = '0;
   logic [ADDR_W-1:0]   io_addr = '0;
   logic [NUM_BATT-1:0] batt = '0;
   logic [2:0]          waddr = '0;
   logic [7:0]          wdata = '0;
   logic [1:0]          mode;
   logic                clk_fast, smi;
   logic [NUM_PINS-1:0] pmc;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pm_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .act_src_i(act), .io_stb_i(io_stb),
      .io_addr_i(io_addr), .batt_low_i(batt), .cfg_we_i(we), .cfg_addr_i(waddr),
      .cfg_wdata_i(wdata), .mode_o(mode), .clk_fast_o(clk_fast), .smi_req_o(smi),
      .pmc_o(pmc)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); we = 1'b1; waddr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic pulse_act(input logic [NUM_ACT-1:0] s);
      @(negedge clk); act = s;
      @(negedge clk); act = '0;
   endtask

   task automatic io_acc(input logic [ADDR_W-1:0] a);
      @(negedge clk); io_stb = 1'b1; io_addr = a;
      @(negedge clk); io_stb = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mode", mode, 2'b00);
      check("R1 clk_fast", clk_fast, 1);
      check("R1 smi", smi, 0);
      check("R1 pmc", pmc, 5'b01000);

      // R2 fine-range sweep
      wr(3'd1, 8'h00);
      for (int n = 1; n <= 8; n++) begin
         wr(3'd0, 8'(n));
         pulse_act(4'b0001);
         check("R6 wake", mode, 2'b00);
         ticks(n - 1);
         check("R2 before limit", mode, 2'b00);
         ticks(1);
         check("R2 at limit", mode, 2'b01);
         check("R1 clk_fast slow", clk_fast, 0);
      end

      // R3 coarse-range sweep
      wr(3'd1, 8'h01);
      for (int n = 1; n <= 3; n++) begin
         wr(3'd0, 8'(n));
         pulse_act(4'b0100);
         ticks(n * PRESCALE - 1);
         check("R3 before limit", mode, 2'b00);
         ticks(1);
         check("R3 at limit", mode, 2'b01);
      end

      // R4 reload by enabled activity
      wr(3'd1, 8'h00);
      wr(3'd0, 8'd4);
      pulse_act(4'b0001);
      ticks(3);
      pulse_act(4'b0001);
      ticks(3);
      check("R4 reloaded", mode, 2'b00);
      ticks(1);
      check("R4 expire", mode, 2'b01);

      // R5 masked source ignored, R6 enabled source wakes on next clock
      wr(3'd4, 8'h01);
      pulse_act(4'b0100);
      check("R5 masked no wake", mode, 2'b01);
      @(negedge clk); act = 4'b0001;
      @(negedge clk); act = '0;
      check("R6 next-clock wake", mode, 2'b00);
      ticks(3);
      pulse_act(4'b0100);
      ticks(1);
      check("R5 masked no reload", mode, 2'b01);
      wr(3'd4, 8'h0F);
      pulse_act(4'b0001);

      // R7 limit zero disables drop
      wr(3'd0, 8'd0);
      pulse_act(4'b0001);
      ticks(40);
      check("R7 no drop", mode, 2'b00);

      // R8 battery forces slow mode
      @(negedge clk); batt = 2'b10;
      @(negedge clk);
      check("R8 forced", mode, 2'b01);
      pulse_act(4'b0001);
      check("R8 no wake while low", mode, 2'b01);
      @(negedge clk); batt = 2'b00;
      pulse_act(4'b0001);
      check("R8 wake after release", mode, 2'b00);

      // R9 battery SMI pulse
      wr(3'd1, 8'h02);
      @(negedge clk); batt = 2'b01;
      @(negedge clk);
      check("R9 smi high", smi, 1);
      @(negedge clk);
      check("R9 smi single", smi, 0);
      check("R9 mode kept", mode, 2'b00);
      @(negedge clk); batt = 2'b00;
      @(negedge clk);

      // R10 per-mode pin levels
      wr(3'd2, 8'h15);
      wr(3'd3, 8'h06);
      check("R10 write no effect", pmc, 5'b01000);
      wr(3'd0, 8'd1);
      pulse_act(4'b0001);
      ticks(1);
      check("R10 slow levels", pmc, 5'b00110);
      pulse_act(4'b0001);
      check("R10 fast levels", pmc, 5'b10101);

      // R11/R12 device window timer, pin 1 selected
      wr(3'd0, 8'd0);
      pulse_act(4'b0001);
      wr(3'd1, 8'h06);
      wr(3'd5, 8'hA5);
      wr(3'd6, 8'd3);
      io_acc(10'h297);
      ticks(2);
      check("R11 before expire", pmc, 5'b10101);
      ticks(1);
      check("R11 device off", pmc, 5'b10111);
      io_acc(10'h100);
      check("R12 outside no clear", pmc, 5'b10111);
      io_acc(10'h294);
      check("R12 inside clears", pmc, 5'b10101);
      ticks(2);
      io_acc(10'h298);
      ticks(1);
      check("R12 outside no restart", pmc, 5'b10111);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule